// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Byte-Lane Decoder

This block connects a 16-bit multiplexed address/data bus, as driven by a small microcontroller, to an external memory or peripheral built from two 8-bit byte lanes. The shared lines first carry an address while the bus phase clock E is low, and then carry data while E is high. The block samples the bus with a fast system clock. It captures the address at the moment E is first seen high, and it holds that address steady until the next bus cycle begins.

From the low address bit and the active-low low-byte strobe, the block decides whether the access touches the even lane (the upper bus half), the odd lane (the lower bus half) or both. It then raises registered chip enables and read or write strobes for the data phase. On a write it forwards each bus half to its own lane. On a read it returns the lane read data to the bus and enables the bus drivers only for the lanes taking part, only while E is high. The bus pins themselves are modelled as separate in, out and output-enable signals, which suits an FPGA I/O buffer.

Top module: `mbd_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `addr_lat`, `ce_even`, `ce_odd`, `mem_oe`, `mem_we`, `ad_oe_hi`, `ad_oe_lo`, `ad_out`, `wr_even` and `wr_odd` are all zero.
- R2: On the first clock edge at which `e_clk` is high after being low, `addr_lat` takes the `ad_in` value sampled on the previous clock edge. It then keeps that value, whatever `ad_in` does, until the next rising E.
- R3: Address bit 0 = 0 with `lstrb_n` = 0 is a 16-bit access: both `ce_even` and `ce_odd` assert for the data phase.
- R4: Address bit 0 = 0 with `lstrb_n` = 1 asserts `ce_even` only.
- R5: Address bit 0 = 1 with `lstrb_n` = 0 asserts `ce_odd` only.
- R6: Address bit 0 = 1 with `lstrb_n` = 1 is illegal. No lane enable, no `mem_oe`, no `mem_we` and no bus drive is asserted for that cycle.
- R7: With `rw` = 1 (read), `mem_oe` is high and `mem_we` is low for the data phase. `ad_oe_hi` follows `ce_even` and `ad_oe_lo` follows `ce_odd`. `ad_out[15:8]` carries `rd_even` and `ad_out[7:0]` carries `rd_odd`, each registered one clock.
- R8: With `rw` = 0 (write), `mem_we` is high for the data phase and `mem_oe` is low. While `e_clk` is high, `wr_even` takes `ad_in[15:8]` and `wr_odd` takes `ad_in[7:0]`, each registered one clock.
- R9: Lane enables, strobes and bus drive assert on the clock edge that first sees E high, and all drop on the clock edge that first sees E low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than E |
| rst | input | 1 | Synchronous active-high reset |
| e_clk | input | 1 | Bus phase clock: low = address phase, high = data phase |
| rw | input | 1 | 1 = read, 0 = write |
| lstrb_n | input | 1 | Active-low low-byte strobe |
| ad_in | input | 16 | Multiplexed bus, input side |
| ad_out | output | 16 | Read data returned to the bus |
| ad_oe_hi | output | 1 | Drive enable for bus bits 15:8 |
| ad_oe_lo | output | 1 | Drive enable for bus bits 7:0 |
| addr_lat | output | 16 | Latched address |
| ce_even | output | 1 | Even (upper) lane enable |
| ce_odd | output | 1 | Odd (lower) lane enable |
| mem_oe | output | 1 | Read strobe to the lanes |
| mem_we | output | 1 | Write strobe to the lanes |
| rd_even | input | 8 | Read data from the even lane |
| rd_odd | input | 8 | Read data from the odd lane |
| wr_even | output | 8 | Write data to the even lane |
| wr_odd | output | 8 | Write data to the odd lane |

## Verification
The hardest situation to reach from the ports is an address latch that picks up the wrong bus sample. The bus changes to data in the same clock in which E rises, so latching one clock late would still look right if the address and the data were equal. The stimulus therefore puts a different value on the data phase in every cycle: write data on a write and a junk pattern on a read. It also places another junk value on the bus as soon as E falls. Checking `addr_lat` both during the data phase and after E has dropped then exposes any off-by-one capture, and any failure to hold the address.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_EVEN = 2'b01,
    LANE_ODD  = 2'b10,
    LANE_BOTH = 2'b11
  } lane_sel_e;

  // Low address bit and active-low low-byte strobe pick the lanes.
  function automatic lane_sel_e decode_lanes(input logic a0, input logic lstrb_n);
    lane_sel_e sel;
    case ({a0, lstrb_n})
      2'b00:   sel = LANE_BOTH;
      2'b01:   sel = LANE_EVEN;
      2'b10:   sel = LANE_ODD;
      default: sel = LANE_NONE;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/mbd_phase_track.sv
module mbd_phase_track (
  input  logic clk,
  input  logic rst,
  input  logic e_clk,
  output logic e_rise,
  output logic e_fall,
  output logic data_phase
);
  logic e_q;

  always_ff @(posedge clk) begin
    if (rst) e_q <= 1'b0;
    else     e_q <= e_clk;
  end

  assign e_rise = e_clk & ~e_q;
  assign e_fall = ~e_clk & e_q;

  always_ff @(posedge clk) begin
    if (rst)         data_phase <= 1'b0;
    else if (e_rise) data_phase <= 1'b1;
    else if (e_fall) data_phase <= 1'b0;
  end

  AST_PHASE_TRACKS_E: assert property (@(posedge clk) disable iff (rst)
    e_fall |=> !data_phase); // R9
endmodule

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e_rise,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic              rw,
  input  logic              lstrb_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic              a0_s,
  output logic              rw_s,
  output logic              lstrb_s
);
  logic [ADDR_W-1:0] ad_s;

  // One-clock sample of the bus; at the rise it still holds the address.
  always_ff @(posedge clk) begin
    if (rst) begin
      ad_s    <= '0;
      rw_s    <= 1'b0;
      lstrb_s <= 1'b1;
    end else begin
      ad_s    <= ad_in;
      rw_s    <= rw;
      lstrb_s <= lstrb_n;
    end
  end

  assign a0_s = ad_s[0];

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (e_rise) addr_q <= ad_s;
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !e_rise |=> $stable(addr_q)); // R2
endmodule

// File: rtl/mbd_strobe_gen.sv
module mbd_strobe_gen
  import mbd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic e_rise,
  input  logic e_fall,
  input  logic a0_s,
  input  logic lstrb_s,
  input  logic rw_s,
  output logic ce_even,
  output logic ce_odd,
  output logic mem_oe,
  output logic mem_we,
  output logic oe_hi,
  output logic oe_lo
);
  lane_sel_e sel;
  logic      legal;
  logic      sel_even;
  logic      sel_odd;

  assign sel      = decode_lanes(a0_s, lstrb_s);
  assign legal    = (sel != LANE_NONE);
  assign sel_even = (sel == LANE_EVEN) || (sel == LANE_BOTH);
  assign sel_odd  = (sel == LANE_ODD)  || (sel == LANE_BOTH);

  always_ff @(posedge clk) begin
    if (rst || e_fall) begin
      ce_even <= 1'b0;
      ce_odd  <= 1'b0;
      mem_oe  <= 1'b0;
      mem_we  <= 1'b0;
      oe_hi   <= 1'b0;
      oe_lo   <= 1'b0;
    end else if (e_rise) begin
      ce_even <= sel_even;
      ce_odd  <= sel_odd;
      mem_oe  <= legal & rw_s;
      mem_we  <= legal & ~rw_s;
      oe_hi   <= sel_even & rw_s;
      oe_lo   <= sel_odd & rw_s;
    end
  end

  AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(mem_oe && mem_we)); // R7
  AST_STROBE_NEEDS_LANE: assert property (@(posedge clk) disable iff (rst)
    (mem_oe || mem_we) |-> (ce_even || ce_odd)); // R6
endmodule

// File: rtl/mbd_data_steer.sv
module mbd_data_steer #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    e_clk,
  input  logic [LANES*LANE_W-1:0] ad_in,
  input  logic [LANES*LANE_W-1:0] rd_lanes,
  output logic [LANES*LANE_W-1:0] ad_out,
  output logic [LANES*LANE_W-1:0] wr_lanes
);
  // Lane i occupies bus slice (LANES-1-i); lane 0 (even) is the upper half.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LO = (LANES - 1 - i) * LANE_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        wr_lanes[LO +: LANE_W] <= '0;
        ad_out[LO +: LANE_W]   <= '0;
      end else begin
        if (e_clk) wr_lanes[LO +: LANE_W] <= ad_in[LO +: LANE_W];
        ad_out[LO +: LANE_W] <= rd_lanes[LO +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/mbd_top.sv
module mbd_top #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                e_clk,
  input  logic                rw,
  input  logic                lstrb_n,
  input  logic [2*LANE_W-1:0] ad_in,
  output logic [2*LANE_W-1:0] ad_out,
  output logic                ad_oe_hi,
  output logic                ad_oe_lo,
  output logic [2*LANE_W-1:0] addr_lat,
  output logic                ce_even,
  output logic                ce_odd,
  output logic                mem_oe,
  output logic                mem_we,
  input  logic [LANE_W-1:0]   rd_even,
  input  logic [LANE_W-1:0]   rd_odd,
  output logic [LANE_W-1:0]   wr_even,
  output logic [LANE_W-1:0]   wr_odd
);
  localparam int BUS_W = 2 * LANE_W;

  logic             e_rise, e_fall, data_phase;
  logic             a0_s, rw_s, lstrb_s;
  logic [BUS_W-1:0] wr_bus;

  mbd_phase_track u_phase (
    .clk(clk), .rst(rst), .e_clk(e_clk),
    .e_rise(e_rise), .e_fall(e_fall), .data_phase(data_phase)
  );

  mbd_addr_latch #(.ADDR_W(BUS_W)) u_latch (
    .clk(clk), .rst(rst), .e_rise(e_rise), .ad_in(ad_in),
    .rw(rw), .lstrb_n(lstrb_n), .addr_q(addr_lat),
    .a0_s(a0_s), .rw_s(rw_s), .lstrb_s(lstrb_s)
  );

  mbd_strobe_gen u_strobe (
    .clk(clk), .rst(rst), .e_rise(e_rise), .e_fall(e_fall),
    .a0_s(a0_s), .lstrb_s(lstrb_s), .rw_s(rw_s),
    .ce_even(ce_even), .ce_odd(ce_odd), .mem_oe(mem_oe), .mem_we(mem_we),
    .oe_hi(ad_oe_hi), .oe_lo(ad_oe_lo)
  );

  mbd_data_steer #(.LANE_W(LANE_W), .LANES(2)) u_steer (
    .clk(clk), .rst(rst), .e_clk(e_clk), .ad_in(ad_in),
    .rd_lanes({rd_even, rd_odd}), .ad_out(ad_out), .wr_lanes(wr_bus)
  );

  assign wr_even = wr_bus[BUS_W-1:LANE_W];
  assign wr_odd  = wr_bus[LANE_W-1:0];

  AST_BOTH_EVEN_ADDR: assert property (@(posedge clk) disable iff (rst)
    (ce_even && ce_odd) |-> !addr_lat[0]); // R3
  AST_EVEN_ONLY_ADDR: assert property (@(posedge clk) disable iff (rst)
    (ce_even && !ce_odd) |-> !addr_lat[0]); // R4
  AST_ODD_ONLY_ADDR: assert property (@(posedge clk) disable iff (rst)
    (ce_odd && !ce_even) |-> addr_lat[0]); // R5
  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (ad_oe_hi || ad_oe_lo) |-> mem_oe); // R7
  AST_WE_IN_E_HIGH: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(e_clk) && data_phase)); // R8
endmodule

// File: tb/test_mbd_top.sv
module test_mbd_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        e_clk, rw, lstrb_n;
  logic [15:0] ad_in, ad_out, addr_lat;
  logic        ad_oe_hi, ad_oe_lo, ce_even, ce_odd, mem_oe, mem_we;
  logic [7:0]  rd_even, rd_odd, wr_even, wr_odd;

  always #10 clk = ~clk;

  mbd_top i_mbd_top (
    .clk(clk), .rst(rst), .e_clk(e_clk), .rw(rw), .lstrb_n(lstrb_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe_hi(ad_oe_hi), .ad_oe_lo(ad_oe_lo),
    .addr_lat(addr_lat), .ce_even(ce_even), .ce_odd(ce_odd),
    .mem_oe(mem_oe), .mem_we(mem_we), .rd_even(rd_even), .rd_odd(rd_odd),
    .wr_even(wr_even), .wr_odd(wr_odd)
  );

  typedef struct {
    string       tag;
    logic [15:0] addr;
    logic [5:0]  ctl;    // ce_even ce_odd mem_oe mem_we ad_oe_hi ad_oe_lo
    logic        chk_rd;
    logic [15:0] rd;
    logic        chk_wr;
    logic [15:0] wr;
  } exp_t;

  exp_t  exp_q[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // Monitor: pops one expected item per event and compares it with the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [5:0] act_ctl;
        e = exp_q.pop_front();
        act_ctl = {ce_even, ce_odd, mem_oe, mem_we, ad_oe_hi, ad_oe_lo};
        checks++;
        if (addr_lat !== e.addr || act_ctl !== e.ctl ||
            (e.chk_rd && ad_out !== e.rd) ||
            (e.chk_wr && {wr_even, wr_odd} !== e.wr)) begin
          errors++;
          $display("FAIL %s: addr=%h ctl=%b ad_out=%h wr=%h, expected addr=%h ctl=%b ad_out=%h wr=%h",
                   e.tag, addr_lat, act_ctl, ad_out, {wr_even, wr_odd},
                   e.addr, e.ctl, e.rd, e.wr);
        end
      end
    end
  end

  function automatic string lane_tag(logic a0, logic ls);
    case ({a0, ls})
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // Driver: one full bus cycle, pushing expectations for the data phase
  // and for the cycle after E falls.
  task automatic bus_cycle(input logic [15:0] a, input logic rd_not_wr,
                           input logic ls, input logic [15:0] dat);
    exp_t e;
    logic ev, od, lg;
    ev = (a[0] == 1'b0);
    od = (ls == 1'b0);
    lg = ev | od;
    @(negedge clk);
    e_clk = 1'b0; ad_in = a; rw = rd_not_wr; lstrb_n = ls;
    @(negedge clk);
    @(negedge clk);
    e_clk = 1'b1;
    if (rd_not_wr) begin
      ad_in = ~a ^ 16'h5A5A;
      rd_even = dat[15:8]; rd_odd = dat[7:0];
    end else begin
      ad_in = dat;
    end
    @(negedge clk);
    e.tag    = {lane_tag(a[0], ls), rd_not_wr ? " R7" : " R8", " R2 R9"};
    e.addr   = a;
    e.ctl    = {ev, od, lg & rd_not_wr, lg & ~rd_not_wr,
                ev & rd_not_wr, od & rd_not_wr};
    e.chk_rd = rd_not_wr;
    e.rd     = dat;
    e.chk_wr = ~rd_not_wr;
    e.wr     = dat;
    exp_q.push_back(e);
    ->chk_ev;
    @(negedge clk);
    @(negedge clk);
    e_clk = 1'b0; ad_in = 16'hFFFF;
    @(negedge clk);
    e.tag    = "R9 R2 after E fall";
    e.ctl    = '0;
    e.chk_rd = 1'b0;
    exp_q.push_back(e);
    ->chk_ev;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t r;
    rst = 1'b1; e_clk = 1'b0; rw = 1'b1; lstrb_n = 1'b1;
    ad_in = 16'h1234; rd_even = 8'hAA; rd_odd = 8'h55;
    repeat (3) @(negedge clk);
    rst = 1'b0; rd_even = 8'h00; rd_odd = 8'h00;
    // R1: reset state, first cycle after release (ad_out registers rd = 0)
    r.tag = "R1 reset"; r.addr = '0; r.ctl = '0;
    r.chk_rd = 1'b1; r.rd = 16'h0000; r.chk_wr = 1'b1; r.wr = 16'h0000;
    exp_q.push_back(r);
    ->chk_ev;

    bus_cycle(16'h4000, 1'b0, 1'b0, 16'hBEEF); // R3 write
    bus_cycle(16'h4000, 1'b1, 1'b0, 16'hC0DE); // R3 read
    bus_cycle(16'h1236, 1'b0, 1'b1, 16'h7E00); // R4 write
    bus_cycle(16'h8AB2, 1'b1, 1'b1, 16'h9911); // R4 read
    bus_cycle(16'h0F01, 1'b0, 1'b0, 16'h0033); // R5 write
    bus_cycle(16'hFFFD, 1'b1, 1'b0, 16'h44E7); // R5 read
    bus_cycle(16'h2469, 1'b0, 1'b1, 16'h1357); // R6 write, illegal
    bus_cycle(16'h0001, 1'b1, 1'b1, 16'h2468); // R6 read, illegal
    bus_cycle(16'hA5A4, 1'b1, 1'b0, 16'h0F0F); // R3 read after illegal
    bus_cycle(16'h0000, 1'b0, 1'b1, 16'hFFFF); // R4 write, zero address

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule